// File: doc/BRIEF.md
# DSI Bus-Turnaround Timing Controller

This block sits in a DSI host beside the packet transmitter and controls the reversal of link direction after the host has asked the peripheral for data. The transmitter gives a one-cycle trigger when a read-type packet or a set-tear-on write has finished. The controller then waits a programmable holding interval and gives a single-cycle turnaround request to the PHY. After that it watches the PHY for the direction change and for the end of the low-power response.

Two watchdog timers limit each wait. One bounds the time from the turnaround request to the PHY's acknowledgement. The other bounds the low-power receive phase, and it runs only while the PHY reports low-power receive mode. Every interval is counted in escape-clock ticks. A tick is a one-cycle enable strobe, derived inside the block from the system clock by a fixed divider, so the logic uses a single clock. Expired timeouts and ignored triggers leave sticky flags. Software clears these flags with a write-one-to-clear input.

Top module: `dsi_turnaround_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `busy_o`, `bta_req_o`, `done_o` and all three flags are 0.
- R2: A `trig_i` pulse taken while idle loads `hold_cnt_i`. The count drops by one on each escape tick, and in the cycle after it reaches zero `bta_req_o` is high for exactly one cycle. A hold count of 0 gives `bta_req_o` in the second cycle after the trigger edge.
- R3: After the turnaround request the turnaround timer is loaded from `bta_tmo_i`. If `phy_turn_ack_i` has not arrived by the tick that would take the timer to zero, `bta_tmo_flag_o` is set and the block returns to idle with no `done_o`. A load of 0 or 1 expires on the first tick.
- R4: After the acknowledgement the receive timer is loaded from `rx_tmo_i`. It counts ticks only while `phy_rx_lp_i` is high, and it expires on the same rule as R3. On expiry `rx_tmo_flag_o` is set and the block returns to idle.
- R5: In the receive phase, if `phy_rx_valid_i` has been high and then is seen low, `done_o` is high for one cycle and `busy_o` falls in the next cycle.
- R6: If `phy_turn_ack_i` arrives in the same cycle as a turnaround-timer expiry, the acknowledgement takes priority: no flag is set and the receive phase begins.
- R7: A `trig_i` seen while `busy_o` is high does not change the sequence in progress and sets `overrun_flag_o`.
- R8: The flags are sticky. Bit 0 of `flag_clr_i` clears `bta_tmo_flag_o`, bit 1 clears `rx_tmo_flag_o` and bit 2 clears `overrun_flag_o`. A set in the same cycle wins over a clear.
- R9: An escape tick happens once every `ESC_DIV` clocks, starting with the `ESC_DIV`-th clock after reset. No hold count or timeout count changes between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Pulse: read or tear-on packet finished |
| hold_cnt_i | input | 16 | Holding interval in escape ticks |
| bta_tmo_i | input | 8 | Turnaround timeout in escape ticks |
| rx_tmo_i | input | 16 | Receive timeout in escape ticks |
| phy_turn_ack_i | input | 1 | PHY has observed the direction change |
| phy_rx_lp_i | input | 1 | PHY is in low-power receive mode |
| phy_rx_valid_i | input | 1 | PHY receive data valid |
| flag_clr_i | input | 3 | Write-one-to-clear for the flags {overrun, rx, bta} |
| bta_req_o | output | 1 | One-cycle turnaround request to the PHY |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bta_tmo_flag_o | output | 1 | Sticky turnaround-timeout flag |
| rx_tmo_flag_o | output | 1 | Sticky receive-timeout flag |
| overrun_flag_o | output | 1 | Sticky ignored-trigger flag |

## Verification
The hardest case to reach is an acknowledgement that lands exactly on the tick that would expire the turnaround timer. The tick phase is hidden, and the timer has a short life. The bench keeps its own model of the divider and of the sequence. It holds the acknowledgement back until the model shows the block waiting for the turnaround with a tick due at the next edge, and only then raises the acknowledgement with a one-tick timeout. A long stretch with the low-power indicator low checks that the receive timer is paused rather than running.

// File: rtl/dsi_turnaround_pkg.sv
// Package: shared state encoding, flag positions and width helper for the
// turnaround controller. Assumes nothing beyond IEEE 1800-2017.
package dsi_turnaround_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_HOLD      = 3'd1,
        ST_BTA_REQ   = 3'd2,
        ST_WAIT_TURN = 3'd3,
        ST_RX_LP     = 3'd4,
        ST_DONE      = 3'd5
    } ta_state_e;

    localparam int FLAG_BTA = 0;
    localparam int FLAG_RX  = 1;
    localparam int FLAG_OVR = 2;
    localparam int NUM_FLAGS = 3;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ta_esc_tick.sv
// Escape-tick generator: a free-running divider that gives a one-cycle
// enable every DIV system clocks. The first tick comes DIV clocks after
// reset is released. Assumes DIV >= 1.
module ta_esc_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV > 1) begin : g_div
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] phase;

            // Advance the phase counter and wrap it at the last phase.
            always_ff @(posedge clk) begin
                if (!rst_n)              phase <= '0;
                else if (phase == LAST)  phase <= '0;
                else                     phase <= phase + 1'b1;
            end

            assign tick_o = (phase == LAST);
        end else begin : g_nodiv
            assign tick_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/ta_down_timer.sv
// Loadable down counter that decrements on request and stops at zero.
// It reports zero, and "one or less" so that the caller can see the last
// step. Load has priority over decrement.
module ta_down_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o,
    output logic         last_o
);
    logic [W-1:0] count;

    // Load, decrement down to zero, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count <= '0;
        else if (load_i)             count <= load_val_i;
        else if (dec_i && count != 0) count <= count - 1'b1;
    end

    assign zero_o = (count == '0);
    assign last_o = (count <= W'(1));
endmodule

// File: rtl/ta_sticky_flags.sv
// Bank of sticky flags. Each bit is set by its set input and cleared by a
// write-one-to-clear bit. A set in the same cycle wins.
module ta_sticky_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            // Hold the flag; a set wins over a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)        flag_o[i] <= 1'b0;
                else if (set_i[i]) flag_o[i] <= 1'b1;
                else if (clr_i[i]) flag_o[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/dsi_turnaround_ctrl.sv
// Turnaround controller: after a read or tear-on packet trigger it waits the
// hold interval, requests a bus turnaround, then checks the PHY acknowledge
// and the low-power receive phase with two tick-based timeouts.
// Assumes trig_i is a one-cycle pulse and that the PHY inputs are already
// synchronous to clk.
module dsi_turnaround_ctrl
    import dsi_turnaround_pkg::*;
#(
    parameter int ESC_DIV = 4,
    parameter int HOLD_W  = 16,
    parameter int BTA_W   = 8,
    parameter int RX_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [HOLD_W-1:0] hold_cnt_i,
    input  logic [BTA_W-1:0]  bta_tmo_i,
    input  logic [RX_W-1:0]   rx_tmo_i,
    input  logic              phy_turn_ack_i,
    input  logic              phy_rx_lp_i,
    input  logic              phy_rx_valid_i,
    input  logic [2:0]        flag_clr_i,
    output logic              bta_req_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              bta_tmo_flag_o,
    output logic              rx_tmo_flag_o,
    output logic              overrun_flag_o
);
    localparam int CNT_W = max3(HOLD_W, BTA_W, RX_W);

    ta_state_e              state, state_nx;
    logic                   esc_tick;
    logic                   tmr_load, tmr_dec, tmr_zero, tmr_last;
    logic [CNT_W-1:0]       tmr_val;
    logic [NUM_FLAGS-1:0]   flag_set, flag_q;
    logic                   valid_seen;

    ta_esc_tick #(.DIV(ESC_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (esc_tick)
    );

    ta_down_timer #(.W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .zero_o     (tmr_zero),
        .last_o     (tmr_last)
    );

    ta_sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr_i),
        .flag_o (flag_q)
    );

    // Next state, timer control and flag events for the sequence.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        tmr_val  = '0;
        flag_set = '0;
        flag_set[FLAG_OVR] = trig_i && (state != ST_IDLE);
        case (state)
            ST_IDLE: begin
                if (trig_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(hold_cnt_i);
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_zero)      state_nx = ST_BTA_REQ;
                else if (esc_tick) tmr_dec  = 1'b1;
            end
            ST_BTA_REQ: begin
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(bta_tmo_i);
                state_nx = ST_WAIT_TURN;
            end
            ST_WAIT_TURN: begin
                if (phy_turn_ack_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(rx_tmo_i);
                    state_nx = ST_RX_LP;
                end else if (esc_tick) begin
                    if (tmr_last) begin
                        flag_set[FLAG_BTA] = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
            end
            ST_RX_LP: begin
                if (valid_seen && !phy_rx_valid_i) begin
                    state_nx = ST_DONE;
                end else if (phy_rx_lp_i && esc_tick) begin
                    if (tmr_last) begin
                        flag_set[FLAG_RX] = 1'b1;
                        state_nx = ST_IDLE;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
            end
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Remember that receive data was valid during the current receive phase.
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RX_LP) valid_seen <= 1'b0;
        else if (phy_rx_valid_i)         valid_seen <= 1'b1;
    end

    assign bta_req_o      = (state == ST_BTA_REQ);
    assign done_o         = (state == ST_DONE);
    assign busy_o         = (state != ST_IDLE);
    assign bta_tmo_flag_o = flag_q[FLAG_BTA];
    assign rx_tmo_flag_o  = flag_q[FLAG_RX];
    assign overrun_flag_o = flag_q[FLAG_OVR];
endmodule

// File: rtl/dsi_turnaround_ctrl_chk.sv
// Checker for the turnaround controller: temporal properties on its ports
// and on the internal escape tick. It is attached by the bind at the end of
// this file.
module dsi_turnaround_ctrl_chk #(
    parameter int ESC_DIV = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_i,
    input logic       phy_turn_ack_i,
    input logic [2:0] flag_clr_i,
    input logic       bta_req_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       bta_tmo_flag_o,
    input logic       rx_tmo_flag_o,
    input logic       overrun_flag_o,
    input logic       esc_tick
);
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bta_req_o |=> !bta_req_o);

    p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bta_req_o |-> busy_o);

    p_bta_tmo_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bta_tmo_flag_o) |-> !busy_o);

    p_rx_tmo_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_tmo_flag_o) |-> !busy_o);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_ack_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_turn_ack_i && busy_o && !bta_tmo_flag_o && !bta_req_o) |=> !bta_tmo_flag_o);

    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o) |=> overrun_flag_o);

    p_bta_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bta_tmo_flag_o && !flag_clr_i[0]) |=> bta_tmo_flag_o);

    p_rx_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_tmo_flag_o && !flag_clr_i[1]) |=> rx_tmo_flag_o);

    p_one_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bta_req_o, done_o}));

    generate
        if (ESC_DIV > 1) begin : g_tick_chk
            p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
                esc_tick |=> !esc_tick);
        end
    endgenerate
endmodule

bind dsi_turnaround_ctrl dsi_turnaround_ctrl_chk #(.ESC_DIV(ESC_DIV)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trig_i         (trig_i),
    .phy_turn_ack_i (phy_turn_ack_i),
    .flag_clr_i     (flag_clr_i),
    .bta_req_o      (bta_req_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .bta_tmo_flag_o (bta_tmo_flag_o),
    .rx_tmo_flag_o  (rx_tmo_flag_o),
    .overrun_flag_o (overrun_flag_o),
    .esc_tick       (esc_tick)
);

// File: tb/sim_dsi_turnaround_ctrl.sv
// Bench: a behavioural cycle model, compared on every clock, plus directed
// scenarios with checks named after the requirements.
module sim_dsi_turnaround_ctrl;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [15:0] hold = '0;
    logic [7:0]  btat = '0;
    logic [15:0] rxt = '0;
    logic        ack = 1'b0, lp = 1'b0, vld = 1'b0;
    logic [2:0]  clr = '0;
    logic        req, busy, done, fb, fr, fo;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    // model state: 0 idle,1 hold,2 req,3 wait,4 rx,5 done
    int m_st = 0, m_cnt = 0, m_div = 0;
    bit m_seen = 0, m_fb = 0, m_fr = 0, m_fo = 0;

    always #2.5 clk = ~clk;

    dsi_turnaround_ctrl #(.ESC_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .hold_cnt_i(hold),
        .bta_tmo_i(btat), .rx_tmo_i(rxt), .phy_turn_ack_i(ack),
        .phy_rx_lp_i(lp), .phy_rx_valid_i(vld), .flag_clr_i(clr),
        .bta_req_o(req), .busy_o(busy), .done_o(done),
        .bta_tmo_flag_o(fb), .rx_tmo_flag_o(fr), .overrun_flag_o(fo));

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Reference model, advanced at each rising edge.
    always @(posedge clk) begin
        bit tick, sb, sr, so;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_div = 0; m_seen = 0;
            m_fb = 0; m_fr = 0; m_fo = 0;
        end else begin
            tick = (m_div == DIV - 1);
            m_div = tick ? 0 : m_div + 1;
            sb = 0; sr = 0;
            so = trig && (m_st != 0);
            case (m_st)
                0: if (trig) begin m_cnt = hold; m_st = 1; end
                1: if (m_cnt == 0) m_st = 2; else if (tick) m_cnt--;
                2: begin m_cnt = btat; m_st = 3; end
                3: if (ack) begin m_cnt = rxt; m_st = 4; m_seen = 0; end
                   else if (tick) begin
                       if (m_cnt <= 1) begin sb = 1; m_st = 0; end else m_cnt--;
                   end
                4: begin
                    if (m_seen && !vld) m_st = 5;
                    else if (lp && tick) begin
                        if (m_cnt <= 1) begin sr = 1; m_st = 0; end else m_cnt--;
                    end
                    if (vld) m_seen = 1;
                    if (m_st != 4) m_seen = 0;
                end
                default: m_st = 0;
            endcase
            m_fb = sb ? 1 : (clr[0] ? 0 : m_fb);
            m_fr = sr ? 1 : (clr[1] ? 0 : m_fr);
            m_fo = so ? 1 : (clr[2] ? 0 : m_fo);
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            check(req  == (m_st == 2), "R2", "bta_req_o", req, m_st == 2);
            check(done == (m_st == 5), "R5", "done_o", done, m_st == 5);
            check(busy == (m_st != 0), "R9", "busy_o", busy, m_st != 0);
            check(fb == m_fb, "R3", "bta_tmo_flag_o", fb, m_fb);
            check(fr == m_fr, "R4", "rx_tmo_flag_o", fr, m_fr);
            check(fo == m_fo, "R7", "overrun_flag_o", fo, m_fo);
        end
        if (cycles > 100000) begin
            check(0, "R1", "watchdog expired", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig = 1'b1; step(1); trig = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) step(1);
    endtask

    task automatic wait_req();
        for (int i = 0; i < 5000 && !req; i++) step(1);
    endtask

    int nreq, ndone, lat;

    initial begin
        step(3);
        check({busy, req, done, fb, fr, fo} == 6'b0, "R1", "outputs in reset",
              {busy, req, done, fb, fr, fo}, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        check({busy, req, done, fb, fr, fo} == 6'b0, "R1", "outputs after reset",
              {busy, req, done, fb, fr, fo}, 0);

        // Normal sequence
        hold = 3; btat = 5; rxt = 10;
        pulse_trig();
        nreq = 0; ndone = 0;
        for (int i = 0; i < 200 && !req; i++) step(1);
        nreq = req;
        step(2); ack = 1'b1; step(1); ack = 1'b0; lp = 1'b1;
        step(3); vld = 1'b1; step(4); vld = 1'b0;
        for (int i = 0; i < 50 && busy; i++) begin
            if (done) ndone++;
            if (req) nreq++;
            step(1);
        end
        lp = 1'b0;
        check(nreq == 1, "R2", "request pulses", nreq, 1);
        check(ndone == 1, "R5", "done pulses", ndone, 1);
        check(fb == 0 && fr == 0, "R5", "no timeout flags", {fb, fr}, 0);

        // Hold of zero, then turnaround timeout
        hold = 0; btat = 3;
        trig = 1'b1; step(1); trig = 1'b0;
        lat = 1;
        while (!req && lat < 20) begin step(1); lat++; end
        check(lat == 2, "R2", "zero-hold latency", lat, 2);
        ndone = 0;
        for (int i = 0; i < 100 && busy; i++) begin if (done) ndone++; step(1); end
        check(fb == 1, "R3", "bta timeout flag", fb, 1);
        check(ndone == 0, "R3", "no done on timeout", ndone, 0);
        step(10);
        check(fb == 1, "R8", "flag stays set", fb, 1);

        // W1C clear of bta flag only
        clr = 3'b110; step(1); clr = '0;
        check(fb == 1, "R8", "other clear bits leave bta flag", fb, 1);
        clr = 3'b001; step(1); clr = '0;
        check(fb == 0, "R8", "bta flag cleared", fb, 0);

        // Receive timer pauses while lp low, then expires
        hold = 1; btat = 20; rxt = 2;
        pulse_trig(); wait_req(); step(1);
        ack = 1'b1; step(1); ack = 1'b0;
        step(60);
        check(busy == 1 && fr == 0, "R4", "rx timer paused with lp low", {busy, fr}, 2);
        lp = 1'b1;
        wait_idle();
        lp = 1'b0;
        check(fr == 1, "R4", "rx timeout flag", fr, 1);
        clr = 3'b010; step(1); clr = '0;
        check(fr == 0, "R8", "rx flag cleared", fr, 0);

        // Overrun: second trigger while holding
        hold = 5; btat = 2;
        pulse_trig(); step(2);
        pulse_trig();
        check(fo == 1, "R7", "overrun flag", fo, 1);
        nreq = 0;
        for (int i = 0; i < 200 && busy; i++) begin if (req) nreq++; step(1); end
        check(nreq == 1, "R7", "single request despite retrigger", nreq, 1);
        clr = 3'b111; step(1); clr = '0;
        check({fb, fr, fo} == 3'b0, "R8", "all flags cleared", {fb, fr, fo}, 0);

        // Ack coinciding with the expiring tick
        hold = 0; btat = 1; rxt = 30;
        pulse_trig();
        for (int i = 0; i < 100 && !(m_st == 3 && m_div == DIV - 1); i++) step(1);
        ack = 1'b1; step(1); ack = 1'b0;
        check(fb == 0, "R6", "no bta flag when ack on expiry tick", fb, 0);
        check(busy == 1, "R6", "receive phase entered", busy, 1);
        lp = 1'b1; vld = 1'b1; step(2); vld = 1'b0;
        wait_idle(); lp = 1'b0;
        check(fb == 0 && fr == 0, "R6", "sequence completes cleanly", {fb, fr}, 0);

        // Hold duration in ticks
        hold = 4; btat = 2;
        trig = 1'b1; step(1); trig = 1'b0;
        lat = 1;
        while (!req && lat < 100) begin step(1); lat++; end
        check(lat >= 3 * DIV + 2 && lat <= 4 * DIV + 1, "R9", "hold latency in clocks",
              lat, 4 * DIV);
        wait_idle();
        clr = 3'b111; step(2); clr = '0;

        step(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule